// File: doc/BRIEF.md
# Interrupt Mask and Underflow Policy Register

This block is the 32-bit control register that sits between a network controller's latched event flags and its single interrupt request line. It holds five mask bits, one for each event source: missed frame, memory error, receive done, transmit done and initialisation done. A source whose mask bit is 1 may keep its flag set, but it cannot raise the interrupt. The interrupt request is the registered OR of every unmasked flag. The register also holds a look-ahead enable level, which goes to the receive descriptor logic, and a policy bit for transmit underflow.

When a transmit underflow is reported, a three-state machine decides what happens next. In `UF_IDLE` the block waits. An underflow while the policy bit is 0 moves it to `UF_HALT`, and for one cycle it asks for transmitter-on to be cleared. An underflow while the policy bit is 1 moves it to `UF_SKIP`, and for one cycle it asks the transmit side to move ahead to the next start-of-frame descriptor, with the transmitter left running. Both action states go back to `UF_IDLE` on the next cycle, or go straight to an action state again if another underflow arrives at once. A software reset forces `UF_IDLE`. While STOP is asserted, an underflow causes no transition.

A hardware reset or a software reset clears every register bit. STOP never changes the register, and writes are accepted whatever the run state.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After hardware reset (rst_n low), rd_data reads 0, irq_o is 0, and tx_off_o, skip_sof_o and lookahead_en_o are 0.
- R2: A write (wr_en high) loads bits 12:8 (masks), bit 6 (underflow policy) and bit 5 (look-ahead) from wr_data. rd_data returns them at the same positions from the next cycle.
- R3: Bits 31:13, bit 7 and bits 4:0 of rd_data always read 0, whatever value was written to them.
- R4: soft_rst clears bits 12:8, 6 and 5 on the next edge, and takes priority over a write in the same cycle.
- R5: The register value does not change while stop is high with no write. A write during stop still takes effect.
- R6: irq_o is registered. One cycle after the inputs, it equals the OR over i = 0..4 of evt_flags[i] AND NOT rd_data[8+i]. The flag mapping is [4] missed frame, [3] memory error, [2] receive, [1] transmit, [0] init done.
- R7: A flag whose mask bit is 1 never raises irq_o on its own, even though the flag stays set.
- R8: With bit 6 = 0, a tx_underflow pulse (stop low) makes tx_off_o high for exactly the next cycle, with skip_sof_o low.
- R9: With bit 6 = 1, a tx_underflow pulse (stop low) makes skip_sof_o high for exactly the next cycle, with tx_off_o low.
- R10: A tx_underflow arriving while stop is high produces neither tx_off_o nor skip_sof_o.
- R11: lookahead_en_o is a level equal to register bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| soft_rst | input | 1 | Synchronous software reset |
| stop | input | 1 | Run-state STOP level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| evt_flags | input | 5 | Latched event flags, mapping as in R6 |
| tx_underflow | input | 1 | Transmit underflow event pulse |
| irq_o | output | 1 | Combined interrupt request |
| tx_off_o | output | 1 | One-cycle request to clear transmitter-on |
| skip_sof_o | output | 1 | One-cycle request to skip to the next start-of-frame |
| lookahead_en_o | output | 1 | Look-ahead enable level |

## Verification
The hardest situation to reach is an interaction: a flag is set while its mask is set, and another source is also involved. The bench reaches it with a full sweep. It writes each of the 32 mask patterns and then drives each of the 32 flag patterns, so every masked, unmasked and mixed pairing is observed at irq_o one cycle later. The underflow states are reached by pulsing tx_underflow under both policy values with stop both low and high. The same-cycle case of software reset and a write is forced directly.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int REG_W    = 32;
    localparam int NSRC     = 5;
    localparam int MASK_LSB = 8;
    localparam int POL_BIT  = 6;
    localparam int LA_BIT   = 5;

    typedef enum logic [1:0] {
        UF_IDLE = 2'd0,
        UF_HALT = 2'd1,
        UF_SKIP = 2'd2
    } uf_state_e;
endpackage

// File: rtl/irqm_regfile.sv
module irqm_regfile
    import irqm_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int NS   = NSRC,
    parameter int MLSB = MASK_LSB,
    parameter int PBIT = POL_BIT,
    parameter int LBIT = LA_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  reg_o,
    output logic [NS-1:0] mask_o,
    output logic          pol_o,
    output logic          la_o
);
    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] FIELD_WR = W'(((ONE << NS) - ONE) << MLSB)
                                      | (ONE << PBIT) | (ONE << LBIT);

    logic [W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (soft_rst) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= wr_data & FIELD_WR;
        end
    end

    assign reg_o  = reg_q;
    assign mask_o = reg_q[MLSB +: NS];
    assign pol_o  = reg_q[PBIT];
    assign la_o   = reg_q[LBIT];

    assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (mask_o == $past(wr_data[MLSB +: NS])
                                  && pol_o == $past(wr_data[PBIT])
                                  && la_o == $past(wr_data[LBIT])));

    assert_soft_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask_o == '0 && !pol_o && !la_o));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !soft_rst) |=> $stable(reg_o));
endmodule

// File: rtl/irqm_gate.sv
module irqm_gate
    import irqm_pkg::*;
#(
    parameter int NS = NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] flags,
    input  logic [NS-1:0] mask,
    output logic          irq_o
);
    logic [NS-1:0] pass;
    logic          irq_q;

    for (genvar i = 0; i < NS; i++) begin : g_src
        assign pass[i] = flags[i] & ~mask[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pass;
    end

    assign irq_o = irq_q;

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~mask) == '0) |=> !irq_o);
endmodule

// File: rtl/irqm_ufl_fsm.sv
module irqm_ufl_fsm
    import irqm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic stop,
    input  logic policy,
    input  logic underflow,
    output logic tx_off_o,
    output logic skip_o
);
    uf_state_e state_q, state_d;

    always_comb begin
        state_d = UF_IDLE;
        unique case (state_q)
            UF_IDLE, UF_HALT, UF_SKIP: begin
                if (soft_rst)                state_d = UF_IDLE;
                else if (underflow && !stop) state_d = policy ? UF_SKIP : UF_HALT;
                else                         state_d = UF_IDLE;
            end
            default: state_d = UF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_off_o = (state_q == UF_HALT);
        skip_o   = (state_q == UF_SKIP);
    end

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !stop && !policy && !soft_rst) |=> (tx_off_o && !skip_o));

    assert_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !stop && policy && !soft_rst) |=> (skip_o && !tx_off_o));

    assert_stop_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && stop) |=> (!skip_o && !tx_off_o));
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqm_pkg::*;
#(
    parameter int W    = REG_W,
    parameter int NS   = NSRC,
    parameter int MLSB = MASK_LSB,
    parameter int PBIT = POL_BIT,
    parameter int LBIT = LA_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          stop,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    input  logic [NS-1:0] evt_flags,
    input  logic          tx_underflow,
    output logic          irq_o,
    output logic          tx_off_o,
    output logic          skip_sof_o,
    output logic          lookahead_en_o
);
    logic [NS-1:0] mask_w;
    logic          pol_w;

    irqm_regfile #(.W(W), .NS(NS), .MLSB(MLSB), .PBIT(PBIT), .LBIT(LBIT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .reg_o    (rd_data),
        .mask_o   (mask_w),
        .pol_o    (pol_w),
        .la_o     (lookahead_en_o)
    );

    irqm_gate #(.NS(NS)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (evt_flags),
        .mask  (mask_w),
        .irq_o (irq_o)
    );

    irqm_ufl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .stop      (stop),
        .policy    (pol_w),
        .underflow (tx_underflow),
        .tx_off_o  (tx_off_o),
        .skip_o    (skip_sof_o)
    );
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        stop = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  evt_flags = '0;
    logic        tx_underflow = 1'b0;
    logic        irq_o, tx_off_o, skip_sof_o, lookahead_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_mask_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .evt_flags(evt_flags), .tx_underflow(tx_underflow), .irq_o(irq_o),
        .tx_off_o(tx_off_o), .skip_sof_o(skip_sof_o), .lookahead_en_o(lookahead_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic [31:0] visible(input logic [31:0] d);
        return d & 32'h0000_1F60;
    endfunction

    task automatic ufl_pulse(input logic exp_off, input logic exp_skip, input string tag);
        @(negedge clk);
        tx_underflow = 1'b1;
        @(negedge clk);
        tx_underflow = 1'b0;
        chk({tag, " tx_off"}, {31'b0, tx_off_o}, {31'b0, exp_off});
        chk({tag, " skip"}, {31'b0, skip_sof_o}, {31'b0, exp_skip});
        @(negedge clk);
        chk({tag, " one-cycle tx_off"}, {31'b0, tx_off_o}, 32'd0);
        chk({tag, " one-cycle skip"}, {31'b0, skip_sof_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] d, held;
        repeat (3) @(negedge clk);
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 irq", {31'b0, irq_o}, 32'd0);
        chk("R1 tx_off", {31'b0, tx_off_o}, 32'd0);
        chk("R1 skip", {31'b0, skip_sof_o}, 32'd0);
        chk("R1 lookahead", {31'b0, lookahead_en_o}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R11: every mask pattern with junk in reserved bits
        for (int m = 0; m < 32; m++) begin
            d = {16'hA5C3, 3'b111, m[4:0], 1'b1, m[0], m[1], 5'h1F};
            wr(d);
            chk("R2 readback fields", rd_data & 32'h0000_1F60, visible(d));
            chk("R3 reserved bits zero", rd_data & ~32'h0000_1F60, 32'd0);
            chk("R11 lookahead level", {31'b0, lookahead_en_o}, {31'b0, m[1]});
            // R6 R7: sweep every flag pattern against this mask
            for (int f = 0; f < 32; f++) begin
                logic expi;
                expi = |(f[4:0] & ~m[4:0]);
                @(negedge clk);
                evt_flags = f[4:0];
                @(negedge clk);
                if (f != 0 && !expi)
                    chk("R7 masked flags quiet", {31'b0, irq_o}, 32'd0);
                else
                    chk("R6 irq combine", {31'b0, irq_o}, {31'b0, expi});
            end
            evt_flags = '0;
        end

        // R5: stop holds value; write during stop accepted
        wr(32'h0000_1560);
        held = rd_data;
        @(negedge clk); stop = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 held under stop", rd_data, held);
        wr(32'h0000_0A20);
        chk("R5 write during stop", rd_data, 32'h0000_0A20);
        @(negedge clk); stop = 1'b0;

        // R4: soft reset priority over write
        wr(32'hFFFF_FFFF);
        chk("R2 all ones", rd_data, 32'h0000_1F60);
        @(negedge clk);
        soft_rst = 1'b1; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R4 soft reset clears", rd_data, 32'd0);
        chk("R4 lookahead cleared", {31'b0, lookahead_en_o}, 32'd0);

        // R8 policy 0
        wr(32'h0000_0000);
        ufl_pulse(1'b1, 1'b0, "R8");
        // R9 policy 1
        wr(32'h0000_0040);
        ufl_pulse(1'b0, 1'b1, "R9");
        // R10 under stop, both policies
        @(negedge clk); stop = 1'b1;
        ufl_pulse(1'b0, 1'b0, "R10 pol1");
        wr(32'h0000_0000);
        ufl_pulse(1'b0, 1'b0, "R10 pol0");
        @(negedge clk); stop = 1'b0;
        chk("R5 stop left policy", rd_data, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule